// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This controller carries a processor from the moment it accepts a pending interrupt to the moment the first handler instruction can be fetched. It waits for a safe point in the instruction stream and runs a fixed series of steps. It reads a descriptor that holds the source number and the request level, and it clears the request of the acknowledged source. It keeps a private copy of the flag word and then clears the interrupt-enable, single-step and stack-select flags. It saves the old flags and the old program counter, raises the priority field to the request level, and loads the handler address from a vector table.

Two save paths exist. In normal mode the old flags and the old program counter go to memory through the interrupt stack pointer, which is decremented before each write. In fast mode both go to dedicated save registers and the bus carries no writes. A request that arrives during an ordinary instruction waits for that instruction's completion strobe. A request that arrives during an interruptible long instruction cuts that instruction short and starts at once. The core takes the new flags, the new program counter and the new stack pointer when the one-cycle completion pulse appears.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset the block is idle: no bus request, no completion pulse, no acknowledge, and the new-flag and new-PC outputs are zero.
- R2: While a request is pending and no long instruction is running, nothing starts until `insn_bnd_i` is high. The descriptor read is on the bus in the cycle after the cycle in which the strobe was sampled.
- R3: If a request is pending while `insn_long_i` is high, `suspend_o` is high in that same cycle. The descriptor read starts the next cycle, with no boundary strobe needed. Without a long instruction, `suspend_o` stays low.
- R4: The first access is a read at address 0 in normal mode or address 2 in fast mode. The source number is taken from read-data bits [5:0] and the level from bits [10:8]. All other bits are ignored.
- R5: `irq_ack_o` is high for exactly one cycle per sequence: the cycle in which the descriptor read completes.
- R6: The new flag word equals the flags captured at acknowledge, with bits 6 (interrupt enable), 1 (single step) and 7 (stack select) cleared, and with bits [14:12] replaced by the request level.
- R7: In normal mode the old flags are written first, then the old PC. Each is written at the stack pointer minus 4, with the pointer decremented before each write, and each is zero-extended to the data width. The final stack pointer is the start value minus 8.
- R8: In fast mode the old flags and the old PC are held in `save_flg_o` and `save_pc_o`, no bus write happens, and the stack pointer is unchanged.
- R9: The last access is a read at the table base plus 4 times the source number. Bits [23:0] of the data read become the new PC.
- R10: The access order is fixed: descriptor read, then the two saves (normal mode only), then the vector read. A request holds its address, direction and data until `bus_rdy_i` is high.
- R11: `done_o` is high for one cycle, in the cycle after the vector read completes, and the block is idle in that cycle. Pending requests and boundary strobes seen during a sequence do not start a second one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_pend_i | input | 1 | An interrupt request is pending |
| irq_fast_i | input | 1 | The pending request uses the fast save path |
| insn_bnd_i | input | 1 | The current instruction completes this cycle |
| insn_long_i | input | 1 | An interruptible long instruction is executing |
| flg_i | input | 16 | Live flag word of the core |
| pc_i | input | 24 | Live program counter of the core |
| isp_i | input | 24 | Live interrupt stack pointer |
| intb_i | input | 24 | Vector table base address |
| bus_req_o | output | 1 | Bus access request |
| bus_we_o | output | 1 | Access is a write |
| bus_addr_o | output | 24 | Access address |
| bus_wdata_o | output | 32 | Write data |
| bus_rdata_i | input | 32 | Read data, valid together with ready |
| bus_rdy_i | input | 1 | The access completes this cycle |
| irq_ack_o | output | 1 | Clear the request bit of the acknowledged source |
| suspend_o | output | 1 | Abort the long instruction now executing |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | New PC, flags and stack pointer are valid |
| new_flg_o | output | 16 | Flag word for the handler |
| new_pc_o | output | 24 | Handler start address |
| new_isp_o | output | 24 | Interrupt stack pointer after the saves |
| save_flg_o | output | 16 | Fast-mode saved flags |
| save_pc_o | output | 24 | Fast-mode saved PC |

## Verification
The start of a sequence is due one clock after the boundary strobe, or after the long-instruction flag, is sampled. The bench drives these inputs just after a falling edge and looks for the descriptor read at the next falling edge, checking in each waiting cycle before it that no request is on the bus. The bus model adds 0 to 2 random wait cycles and logs each access at the falling edge before the rising edge that completes it. The order and contents of the accesses are therefore compared only after `done_o` is seen. `done_o` is due one clock after the vector read completes, so the new PC, flags, stack pointer and save registers are sampled at the falling edge where `done_o` is high. The pulse is checked to be gone one edge later.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    typedef enum logic [3:0] {
        ST_IDLE  = 4'd0,
        ST_WAIT  = 4'd1,
        ST_INFO  = 4'd2,
        ST_FLAGS = 4'd3,
        ST_SVFLG = 4'd4,
        ST_SVPC  = 4'd5,
        ST_LEVEL = 4'd6,
        ST_VEC   = 4'd7
    } ies_state_e;

endpackage

// File: rtl/ies_flag_xform.sv
module ies_flag_xform #(
    parameter int FW      = 16,
    parameter int LVLW    = 3,
    parameter int IBIT    = 6,
    parameter int DBIT    = 1,
    parameter int UBIT    = 7,
    parameter int IPL_LSB = 12
) (
    input  logic [FW-1:0]   tmp_i,
    input  logic [FW-1:0]   cur_i,
    input  logic [LVLW-1:0] lvl_i,
    output logic [FW-1:0]   masked_o,
    output logic [FW-1:0]   leveled_o
);
    localparam int IPL_MSB = IPL_LSB + LVLW - 1;

    for (genvar k = 0; k < FW; k++) begin : g_bit
        if (k == IBIT || k == DBIT || k == UBIT) begin : g_clr
            assign masked_o[k] = 1'b0;
        end else begin : g_keep
            assign masked_o[k] = tmp_i[k];
        end
        if (k >= IPL_LSB && k <= IPL_MSB) begin : g_lvl
            assign leveled_o[k] = lvl_i[k-IPL_LSB];
        end else begin : g_cur
            assign leveled_o[k] = cur_i[k];
        end
    end
endmodule

// File: rtl/ies_bus_drv.sv
module ies_bus_drv
    import irq_entry_pkg::*;
#(
    parameter int AW             = 24,
    parameter int DW             = 32,
    parameter int FW             = 16,
    parameter int NUMW           = 6,
    parameter int PUSH_BYTES     = 4,
    parameter int INFO_ADDR      = 0,
    parameter int FAST_INFO_ADDR = 2
) (
    input  ies_state_e      st_i,
    input  logic            fast_i,
    input  logic [AW-1:0]   isp_i,
    input  logic [FW-1:0]   tmp_i,
    input  logic [AW-1:0]   pc_i,
    input  logic [AW-1:0]   intb_i,
    input  logic [NUMW-1:0] num_i,
    output logic            req_o,
    output logic            we_o,
    output logic [AW-1:0]   addr_o,
    output logic [DW-1:0]   wdata_o
);
    localparam logic [AW-1:0] DEC       = AW'(PUSH_BYTES);
    localparam logic [AW-1:0] INFO_N    = AW'(INFO_ADDR);
    localparam logic [AW-1:0] INFO_F    = AW'(FAST_INFO_ADDR);

    logic [AW-1:0] vec_addr;
    assign vec_addr = intb_i + (AW'(num_i) << 2);

    always_comb begin
        req_o   = 1'b0;
        we_o    = 1'b0;
        addr_o  = '0;
        wdata_o = '0;
        case (st_i)
            ST_INFO: begin
                req_o  = 1'b1;
                addr_o = fast_i ? INFO_F : INFO_N;
            end
            ST_SVFLG: begin
                req_o   = !fast_i;
                we_o    = !fast_i;
                addr_o  = isp_i - DEC;
                wdata_o = DW'(tmp_i);
            end
            ST_SVPC: begin
                req_o   = !fast_i;
                we_o    = !fast_i;
                addr_o  = isp_i - DEC;
                wdata_o = DW'(pc_i);
            end
            ST_VEC: begin
                req_o  = 1'b1;
                addr_o = vec_addr;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ies_ctrl.sv
module ies_ctrl
    import irq_entry_pkg::*;
#(
    parameter int AW         = 24,
    parameter int DW         = 32,
    parameter int FW         = 16,
    parameter int NUMW       = 6,
    parameter int LVLW       = 3,
    parameter int LVL_LSB    = 8,
    parameter int PUSH_BYTES = 4,
    parameter int IBIT       = 6,
    parameter int DBIT       = 1,
    parameter int UBIT       = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pend_i,
    input  logic            fast_i,
    input  logic            bnd_i,
    input  logic            long_i,
    input  logic [FW-1:0]   flg_i,
    input  logic [AW-1:0]   pc_i,
    input  logic [AW-1:0]   isp_i,
    input  logic [AW-1:0]   intb_i,
    input  logic [DW-1:0]   rdata_i,
    input  logic            rdy_i,
    input  logic [FW-1:0]   masked_i,
    input  logic [FW-1:0]   leveled_i,
    output ies_state_e      st_o,
    output logic            fast_o,
    output logic [NUMW-1:0] num_o,
    output logic [LVLW-1:0] lvl_o,
    output logic [FW-1:0]   tmp_o,
    output logic [FW-1:0]   flg_o,
    output logic [AW-1:0]   pc_o,
    output logic [AW-1:0]   isp_o,
    output logic [AW-1:0]   intb_o,
    output logic [FW-1:0]   svf_o,
    output logic [AW-1:0]   svp_o,
    output logic            done_o,
    output logic            ack_o,
    output logic            suspend_o,
    output logic            busy_o
);
    localparam logic [AW-1:0] DEC = AW'(PUSH_BYTES);

    typedef struct packed {
        ies_state_e      st;
        logic            fast;
        logic [NUMW-1:0] num;
        logic [LVLW-1:0] lvl;
        logic [FW-1:0]   tmp;
        logic [FW-1:0]   flg;
        logic [AW-1:0]   pc;
        logic [AW-1:0]   isp;
        logic [AW-1:0]   intb;
        logic [FW-1:0]   svf;
        logic [AW-1:0]   svp;
        logic            done;
    } regs_t;

    regs_t r_q, r_d;

    logic unused_rdata_hi;
    assign unused_rdata_hi = ^rdata_i[DW-1:AW];

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        ack_o     = 1'b0;
        suspend_o = 1'b0;
        case (r_q.st)
            ST_IDLE, ST_WAIT: begin
                if (pend_i) begin
                    if (long_i || bnd_i) begin
                        suspend_o = long_i;
                        r_d.st    = ST_INFO;
                        r_d.fast  = fast_i;
                        r_d.pc    = pc_i;
                        r_d.isp   = isp_i;
                        r_d.intb  = intb_i;
                    end else begin
                        r_d.st = ST_WAIT;
                    end
                end else begin
                    r_d.st = ST_IDLE;
                end
            end
            ST_INFO: begin
                if (rdy_i) begin
                    ack_o   = 1'b1;
                    r_d.num = rdata_i[NUMW-1:0];
                    r_d.lvl = rdata_i[LVL_LSB +: LVLW];
                    r_d.tmp = flg_i;
                    r_d.st  = ST_FLAGS;
                end
            end
            ST_FLAGS: begin
                r_d.flg = masked_i;
                r_d.st  = ST_SVFLG;
            end
            ST_SVFLG: begin
                if (r_q.fast) begin
                    r_d.svf = r_q.tmp;
                    r_d.st  = ST_SVPC;
                end else if (rdy_i) begin
                    r_d.isp = r_q.isp - DEC;
                    r_d.st  = ST_SVPC;
                end
            end
            ST_SVPC: begin
                if (r_q.fast) begin
                    r_d.svp = r_q.pc;
                    r_d.st  = ST_LEVEL;
                end else if (rdy_i) begin
                    r_d.isp = r_q.isp - DEC;
                    r_d.st  = ST_LEVEL;
                end
            end
            ST_LEVEL: begin
                r_d.flg = leveled_i;
                r_d.st  = ST_VEC;
            end
            ST_VEC: begin
                if (rdy_i) begin
                    r_d.pc   = rdata_i[AW-1:0];
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign st_o   = r_q.st;
    assign fast_o = r_q.fast;
    assign num_o  = r_q.num;
    assign lvl_o  = r_q.lvl;
    assign tmp_o  = r_q.tmp;
    assign flg_o  = r_q.flg;
    assign pc_o   = r_q.pc;
    assign isp_o  = r_q.isp;
    assign intb_o = r_q.intb;
    assign svf_o  = r_q.svf;
    assign svp_o  = r_q.svp;
    assign done_o = r_q.done;
    assign busy_o = (r_q.st != ST_IDLE) && (r_q.st != ST_WAIT);

    // R11: completion lasts one cycle and lands in idle
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |=> !r_q.done);
    a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |-> r_q.st == ST_IDLE);
    // R5: acknowledge leads straight into the flag step
    a_r5_ack_next: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> r_q.st == ST_FLAGS);
    // R3: an abort starts the descriptor read on the next cycle
    a_r3_suspend_start: assert property (@(posedge clk) disable iff (!rst_n)
        suspend_o |=> r_q.st == ST_INFO);
    // R6: the protected flags are already clear when the vector is fetched
    a_r6_flags_clear: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.st == ST_VEC |-> !r_q.flg[IBIT] && !r_q.flg[DBIT] && !r_q.flg[UBIT]);
    // R8: fast mode leaves the stack pointer alone
    a_r8_fast_isp: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.fast && r_q.st == ST_SVPC) |=> $stable(r_q.isp));
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int AW             = 24,
    parameter int DW             = 32,
    parameter int FW             = 16,
    parameter int NUMW           = 6,
    parameter int LVLW           = 3,
    parameter int LVL_LSB        = 8,
    parameter int IPL_LSB        = 12,
    parameter int IBIT           = 6,
    parameter int DBIT           = 1,
    parameter int UBIT           = 7,
    parameter int PUSH_BYTES     = 4,
    parameter int INFO_ADDR      = 0,
    parameter int FAST_INFO_ADDR = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          irq_pend_i,
    input  logic          irq_fast_i,
    input  logic          insn_bnd_i,
    input  logic          insn_long_i,
    input  logic [FW-1:0] flg_i,
    input  logic [AW-1:0] pc_i,
    input  logic [AW-1:0] isp_i,
    input  logic [AW-1:0] intb_i,
    output logic          bus_req_o,
    output logic          bus_we_o,
    output logic [AW-1:0] bus_addr_o,
    output logic [DW-1:0] bus_wdata_o,
    input  logic [DW-1:0] bus_rdata_i,
    input  logic          bus_rdy_i,
    output logic          irq_ack_o,
    output logic          suspend_o,
    output logic          busy_o,
    output logic          done_o,
    output logic [FW-1:0] new_flg_o,
    output logic [AW-1:0] new_pc_o,
    output logic [AW-1:0] new_isp_o,
    output logic [FW-1:0] save_flg_o,
    output logic [AW-1:0] save_pc_o
);
    ies_state_e      st;
    logic            fast;
    logic [NUMW-1:0] num;
    logic [LVLW-1:0] lvl;
    logic [FW-1:0]   tmp, masked, leveled;
    logic [AW-1:0]   intb;

    ies_ctrl #(
        .AW(AW), .DW(DW), .FW(FW), .NUMW(NUMW), .LVLW(LVLW), .LVL_LSB(LVL_LSB),
        .PUSH_BYTES(PUSH_BYTES), .IBIT(IBIT), .DBIT(DBIT), .UBIT(UBIT)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .pend_i(irq_pend_i), .fast_i(irq_fast_i), .bnd_i(insn_bnd_i), .long_i(insn_long_i),
        .flg_i(flg_i), .pc_i(pc_i), .isp_i(isp_i), .intb_i(intb_i),
        .rdata_i(bus_rdata_i), .rdy_i(bus_rdy_i),
        .masked_i(masked), .leveled_i(leveled),
        .st_o(st), .fast_o(fast), .num_o(num), .lvl_o(lvl), .tmp_o(tmp),
        .flg_o(new_flg_o), .pc_o(new_pc_o), .isp_o(new_isp_o), .intb_o(intb),
        .svf_o(save_flg_o), .svp_o(save_pc_o), .done_o(done_o),
        .ack_o(irq_ack_o), .suspend_o(suspend_o), .busy_o(busy_o)
    );

    ies_flag_xform #(
        .FW(FW), .LVLW(LVLW), .IBIT(IBIT), .DBIT(DBIT), .UBIT(UBIT), .IPL_LSB(IPL_LSB)
    ) u_xform (
        .tmp_i(tmp), .cur_i(new_flg_o), .lvl_i(lvl),
        .masked_o(masked), .leveled_o(leveled)
    );

    ies_bus_drv #(
        .AW(AW), .DW(DW), .FW(FW), .NUMW(NUMW), .PUSH_BYTES(PUSH_BYTES),
        .INFO_ADDR(INFO_ADDR), .FAST_INFO_ADDR(FAST_INFO_ADDR)
    ) u_bus (
        .st_i(st), .fast_i(fast), .isp_i(new_isp_o), .tmp_i(tmp), .pc_i(new_pc_o),
        .intb_i(intb), .num_i(num),
        .req_o(bus_req_o), .we_o(bus_we_o), .addr_o(bus_addr_o), .wdata_o(bus_wdata_o)
    );

    // R10: a stalled access keeps every bus field steady
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && !bus_rdy_i) |=> bus_req_o && $stable(bus_addr_o)
                                      && $stable(bus_we_o) && $stable(bus_wdata_o));
    // R8: fast mode never writes to memory
    a_r8_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && fast) |-> !(bus_req_o && bus_we_o));
    // R5: the acknowledge pulse is never longer than one cycle
    a_r5_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack_o |=> !irq_ack_o);
endmodule

// File: tb/test_irq_entry_seq.sv
`timescale 1ns/1ps
module test_irq_entry_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pend = 1'b0, fast = 1'b0, bnd = 1'b0, lng = 1'b0;
    logic [15:0] flg = '0;
    logic [23:0] pc = '0, isp = '0, intb = '0;
    logic        bus_req, bus_we, bus_rdy = 1'b0;
    logic [23:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata = '0;
    logic        ack, suspend, busy, done;
    logic [15:0] new_flg, save_flg;
    logic [23:0] new_pc, new_isp, save_pc;

    int compared = 0, mismatched = 0;
    logic [31:0] cur_info = '0;
    int   log_n = 0;
    logic log_we[8];
    logic [23:0] log_addr[8];
    logic [31:0] log_data[8];

    always #2.5 clk = ~clk;

    irq_entry_seq i_irq_entry_seq (
        .clk(clk), .rst_n(rst_n),
        .irq_pend_i(pend), .irq_fast_i(fast), .insn_bnd_i(bnd), .insn_long_i(lng),
        .flg_i(flg), .pc_i(pc), .isp_i(isp), .intb_i(intb),
        .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_addr_o(bus_addr),
        .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata), .bus_rdy_i(bus_rdy),
        .irq_ack_o(ack), .suspend_o(suspend), .busy_o(busy), .done_o(done),
        .new_flg_o(new_flg), .new_pc_o(new_pc), .new_isp_o(new_isp),
        .save_flg_o(save_flg), .save_pc_o(save_pc)
    );

    function automatic logic [31:0] vec_word(input logic [23:0] a);
        return {8'h5A, a ^ 24'hC3A5F0};
    endfunction

    function automatic logic [15:0] exp_flags(input logic [15:0] f, input logic [2:0] l);
        logic [15:0] r = f;
        r[6] = 1'b0; r[1] = 1'b0; r[7] = 1'b0; r[14:12] = l;
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // bus model: random wait states, logs each access on its ready cycle
    initial begin
        int wcnt = 0;
        forever begin
            @(negedge clk);
            if (bus_req) begin
                if (wcnt == 0) begin
                    bus_rdy = 1'b1;
                    if (!bus_we)
                        bus_rdata = (bus_addr == 24'd0 || bus_addr == 24'd2) ? cur_info
                                                                            : vec_word(bus_addr);
                    else
                        bus_rdata = '0;
                    if (log_n < 8) begin
                        log_we[log_n]   = bus_we;
                        log_addr[log_n] = bus_addr;
                        log_data[log_n] = bus_we ? bus_wdata : 32'h0;
                    end
                    log_n++;
                    wcnt = $urandom % 3;
                end else begin
                    bus_rdy = 1'b0;
                    wcnt--;
                end
            end else begin
                bus_rdy = 1'b0;
            end
        end
    end

    task automatic run_irq(input bit f_mode, input bit l_mode, input int dly,
                           input bit noisy, input logic [5:0] num, input logic [2:0] lvl);
        logic [15:0] f0;
        logic [23:0] pc0, isp0, intb0, va;
        int acks = 0;
        bit fin = 0;
        @(negedge clk); #1;
        f0    = 16'($urandom);
        pc0   = 24'($urandom);
        isp0  = 24'($urandom) | 24'h000100;
        intb0 = 24'($urandom) & 24'hFFFFFC;
        flg = f0; pc = pc0; isp = isp0; intb = intb0;
        cur_info = $urandom;
        cur_info[5:0]  = num;
        cur_info[10:8] = lvl;
        log_n = 0;
        fast = f_mode;
        pend = 1'b1;
        if (l_mode) begin
            lng = 1'b1; #1;
            chk("R3 suspend raised", 32'(suspend), 32'd1);
        end else begin
            bnd = 1'b0;
            for (int i = 0; i < dly; i++) begin
                @(negedge clk); #2;
                chk("R2 held until boundary", 32'(bus_req), 32'd0);
            end
            bnd = 1'b1; #1;
            chk("R3 no suspend without long insn", 32'(suspend), 32'd0);
        end
        @(negedge clk); #1;
        lng = 1'b0; bnd = 1'b0; #1;
        chk("R2 start next cycle", 32'(bus_req), 32'd1);
        chk("R4 info address", 32'(bus_addr), f_mode ? 32'd2 : 32'd0);
        chk("R4 info is read", 32'(bus_we), 32'd0);
        for (int c = 0; c < 200 && !fin; c++) begin
            if (c > 0) begin @(negedge clk); #2; end
            if (ack) begin acks++; pend = noisy; end
            if (noisy && acks > 0) bnd = 1'($urandom);
            if (done) fin = 1;
        end
        pend = 1'b0; bnd = 1'b0;
        if (!fin) begin
            chk("R11 sequence finished", 32'd0, 32'd1);
            return;
        end
        va = intb0 + {16'd0, num, 2'b00};
        chk("R5 one ack", acks, 32'd1);
        chk("R9 new pc", 32'(new_pc), {8'd0, va ^ 24'hC3A5F0});
        chk("R6 new flags", 32'(new_flg), 32'(exp_flags(f0, lvl)));
        if (f_mode) begin
            chk("R8 access count", log_n, 32'd2);
            chk("R8 saved flags", 32'(save_flg), 32'(f0));
            chk("R8 saved pc", 32'(save_pc), 32'(pc0));
            chk("R8 isp unchanged", 32'(new_isp), 32'(isp0));
            chk("R4 first access address", 32'(log_addr[0]), 32'd2);
            chk("R9 vector address", 32'(log_addr[1]), 32'(va));
            chk("R10 vector is read", 32'(log_we[1]), 32'd0);
        end else begin
            chk("R7 access count", log_n, 32'd4);
            chk("R4 first access address", 32'(log_addr[0]), 32'd0);
            chk("R7 flag push is write", 32'(log_we[1]), 32'd1);
            chk("R7 flag push address", 32'(log_addr[1]), 32'(isp0 - 24'd4));
            chk("R7 flag push data", log_data[1], 32'(f0));
            chk("R7 pc push is write", 32'(log_we[2]), 32'd1);
            chk("R7 pc push address", 32'(log_addr[2]), 32'(isp0 - 24'd8));
            chk("R7 pc push data", log_data[2], 32'(pc0));
            chk("R7 final isp", 32'(new_isp), 32'(isp0 - 24'd8));
            chk("R10 vector is read", 32'(log_we[3]), 32'd0);
            chk("R9 vector address", 32'(log_addr[3]), 32'(va));
        end
        @(negedge clk); #2;
        chk("R11 done one cycle", 32'(done), 32'd0);
        chk("R11 idle after done", 32'(busy), 32'd0);
        chk("R11 no second sequence", 32'(bus_req), 32'd0);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        #2;
        chk("R1 no request", 32'(bus_req), 32'd0);
        chk("R1 no done", 32'(done), 32'd0);
        chk("R1 no ack", 32'(ack), 32'd0);
        chk("R1 not busy", 32'(busy), 32'd0);
        chk("R1 flags zero", 32'(new_flg), 32'd0);
        chk("R1 pc zero", 32'(new_pc), 32'd0);
        rst_n = 1'b1;
        run_irq(1'b0, 1'b0, 3, 1'b0, 6'd5, 3'd3);
        run_irq(1'b1, 1'b0, 0, 1'b0, 6'd63, 3'd7);
        run_irq(1'b0, 1'b1, 0, 1'b0, 6'd0, 3'd0);
        run_irq(1'b1, 1'b1, 2, 1'b1, 6'd17, 3'd1);
        run_irq(1'b0, 1'b0, 1, 1'b1, 6'd63, 3'd7);
        for (int n = 0; n < 40; n++)
            run_irq(1'($urandom), 1'($urandom), $urandom % 4, 1'($urandom),
                    6'($urandom), 3'($urandom));
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule